// File: doc/BRIEF.md
# SDRAM Controller Local Request Queue

This block sits between a user port and the command issuer of an SDRAM controller. The user presents read or write requests. Each request carries an address, a burst size and a flag that asks for auto-precharge. Accepted requests go into a short first-in first-out queue. A ready output tells the user whether another request fits. The queue keeps taking requests while memory initialization is still under way, but it passes nothing to the command issuer until the init-done indication is high. The issuer takes requests through a valid/ready handshake.

Write data is pulled from the user. In the cycle after a write is accepted, the block raises a data-request strobe. The user then drives the word during the next cycle, and the block stores it with the queued write. A write is not released downstream until its data is present.

Besides the queue, the block does three simple things. It registers the sequencer's ready-for-user-mode input as the user's init-done. It turns each refresh issued downstream into a one-cycle acknowledge. It forwards read data beats with their valid flag. The read data bus is two or four memory words wide, depending on the rate option.

Top module: `memreq_frontend`

## Requirements
- R1: A request is accepted only in a cycle where `usr_ready` is high and exactly one of `usr_rd_req` / `usr_wr_req` is high. Every accepted request later appears once on the command side.
- R2: The queue holds `DEPTH` (default 4) requests. `usr_ready` is low exactly when `DEPTH` requests are held.
- R3: Requests leave in acceptance order. Address, size, auto-precharge flag and direction (`cmd_write` = 1 for a write, 0 for a read) are carried unchanged.
- R4: `cmd_valid` stays low whenever `usr_init_done` is low. Queued requests are kept, not dropped.
- R5: `usr_init_done` equals `seq_user_mode_rdy` delayed by one clock.
- R6: `usr_refresh_ack` is high for exactly the one clock that follows each cycle in which `iss_refresh_done` is high.
- R7: `usr_wdata_req` is high in the clock after a write is accepted. The word on `usr_wdata` in the clock after that is delivered on `cmd_wdata` with that write. A write is never presented before its word has been taken.
- R8: If both request inputs are high in the same cycle, `usr_proto_err` is high in the next clock and neither request is accepted.
- R9: While `cmd_valid` is high, `cmd_ready` is low and init stays ready, the next cycle keeps `cmd_valid` high with all command fields unchanged.
- R10: `usr_rdata_valid` and `usr_rdata` follow `phy_rdata_valid` / `phy_rdata` by one clock. `usr_rdata` holds its last value when no beat arrives. The bus is `MEM_DW*2` bits wide, or `MEM_DW*4` bits when `HALF_RATE` is set.
- R11: After reset the queue is empty, `usr_ready` is high, and `usr_init_done`, `cmd_valid`, `usr_wdata_req`, `usr_proto_err`, `usr_refresh_ack` and `usr_rdata_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usr_rd_req | input | 1 | Read request |
| usr_wr_req | input | 1 | Write request |
| usr_addr | input | ADDR_W | Request address |
| usr_size | input | SIZE_W | Burst size |
| usr_autopch | input | 1 | Ask for auto-precharge on this access |
| usr_ready | output | 1 | Queue can take a request |
| usr_proto_err | output | 1 | Read and write were requested together in the previous cycle |
| usr_wdata | input | LOCAL_DW | Write data word |
| usr_wdata_req | output | 1 | Drive the write word in the next cycle |
| usr_init_done | output | 1 | Memory interface usable |
| usr_rdata | output | LOCAL_DW | Read data |
| usr_rdata_valid | output | 1 | Read beat valid |
| usr_refresh_ack | output | 1 | One pulse per refresh issued |
| seq_user_mode_rdy | input | 1 | Sequencer ready for user mode |
| iss_refresh_done | input | 1 | A refresh was issued downstream |
| cmd_valid | output | 1 | Command offered to issuer |
| cmd_ready | input | 1 | Issuer takes the command |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_addr | output | ADDR_W | Command address |
| cmd_size | output | SIZE_W | Command burst size |
| cmd_autopch | output | 1 | Issue as read/write with auto-precharge |
| cmd_wdata | output | LOCAL_DW | Write word for the command |
| phy_rdata | input | LOCAL_DW | Read data from the datapath |
| phy_rdata_valid | input | 1 | Read beat valid from the datapath |

## Verification
The bench fills the queue before init is up and checks that ready drops at four entries. A design that miscounted would lose or overwrite requests. It also checks that nothing leaks downstream early, which a design gating on the wrong signal would allow. Init is taken away in the middle of traffic, with a command stalled by a low `cmd_ready`, to catch offers that change or vanish and reorderings. Simultaneous read and write, back-to-back refresh pulses and back-to-back writes are driven too. A design with an off-by-one in the data-request pipeline would pair a write with its neighbour's word, or release a write before its word arrived.

// File: rtl/memreq_pkg.sv
package memreq_pkg;

   typedef enum logic {
      OP_READ  = 1'b0,
      OP_WRITE = 1'b1
   } op_e;

   // local bus width multiplier: full rate carries two memory words, half rate four
   function automatic int unsigned rate_mult(input bit half_rate);
      return half_rate ? 4 : 2;
   endfunction

   function automatic int unsigned ptr_width(input int unsigned depth);
      return (depth <= 2) ? 1 : $clog2(depth);
   endfunction

endpackage

// File: rtl/memreq_queue.sv
module memreq_queue
   import memreq_pkg::*;
#(
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned SIZE_W = 3,
   parameter int unsigned DATA_W = 16,
   localparam int unsigned PW    = ptr_width(DEPTH),
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  op_e               push_op,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic [SIZE_W-1:0] push_size,
   input  logic              push_apch,
   output logic [PW-1:0]     tail_slot,
   input  logic              fill_en,
   input  logic [PW-1:0]     fill_slot,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              release_en,
   output logic              head_valid,
   input  logic              head_take,
   output op_e               head_op,
   output logic [ADDR_W-1:0] head_addr,
   output logic [SIZE_W-1:0] head_size,
   output logic              head_apch,
   output logic [DATA_W-1:0] head_data,
   output logic              full
);

   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
   localparam logic [CW-1:0] CAP  = CW'(DEPTH);

   op_e               e_op   [DEPTH];
   logic [ADDR_W-1:0] e_addr [DEPTH];
   logic [SIZE_W-1:0] e_size [DEPTH];
   logic              e_apch [DEPTH];
   logic [DATA_W-1:0] e_data [DEPTH];
   logic              e_dok  [DEPTH];

   logic [PW-1:0] rd_ptr, wr_ptr;
   logic [CW-1:0] count;
   logic          pop;

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == LAST) ? '0 : p + 1'b1;
   endfunction

   assign full       = (count == CAP);
   assign tail_slot  = wr_ptr;
   assign head_valid = release_en && (count != '0) && e_dok[rd_ptr];
   assign pop        = head_valid && head_take;

   assign head_op   = e_op[rd_ptr];
   assign head_addr = e_addr[rd_ptr];
   assign head_size = e_size[rd_ptr];
   assign head_apch = e_apch[rd_ptr];
   assign head_data = e_data[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= bump(wr_ptr);
         if (pop)  rd_ptr <= bump(rd_ptr);
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            e_op[i]   <= OP_READ;
            e_addr[i] <= '0;
            e_size[i] <= '0;
            e_apch[i] <= 1'b0;
            e_data[i] <= '0;
            e_dok[i]  <= 1'b0;
         end
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (push && wr_ptr == PW'(i)) begin
               e_op[i]   <= push_op;
               e_addr[i] <= push_addr;
               e_size[i] <= push_size;
               e_apch[i] <= push_apch;
               e_dok[i]  <= (push_op == OP_READ);
            end
            if (fill_en && fill_slot == PW'(i)) begin
               e_data[i] <= fill_data;
               e_dok[i]  <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/memreq_wdpipe.sv
module memreq_wdpipe #(
   parameter int unsigned PW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_accept,
   input  logic [PW-1:0] wr_slot,
   output logic          wdata_req,
   output logic          fill_en,
   output logic [PW-1:0] fill_slot
);

   logic [PW-1:0] req_slot;

   // stage 1: strobe to the user; stage 2: capture cycle for the word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wdata_req <= 1'b0;
         req_slot  <= '0;
         fill_en   <= 1'b0;
         fill_slot <= '0;
      end else begin
         wdata_req <= wr_accept;
         if (wr_accept) req_slot <= wr_slot;
         fill_en   <= wdata_req;
         if (wdata_req) fill_slot <= req_slot;
      end
   end

endmodule

// File: rtl/memreq_status.sv
module memreq_status #(
   parameter int unsigned LDW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           seq_rdy,
   input  logic           ref_done,
   input  logic [LDW-1:0] phy_rdata,
   input  logic           phy_rvalid,
   output logic           init_done,
   output logic           ref_ack,
   output logic [LDW-1:0] rdata,
   output logic           rvalid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_done <= 1'b0;
         ref_ack   <= 1'b0;
         rvalid    <= 1'b0;
         rdata     <= '0;
      end else begin
         init_done <= seq_rdy;
         ref_ack   <= ref_done;
         rvalid    <= phy_rvalid;
         if (phy_rvalid) rdata <= phy_rdata;
      end
   end

endmodule

// File: rtl/memreq_frontend.sv
module memreq_frontend
   import memreq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned SIZE_W    = 3,
   parameter int unsigned DEPTH     = 4,
   parameter int unsigned MEM_DW    = 8,
   parameter bit          HALF_RATE = 1'b0,
   localparam int unsigned LOCAL_DW = MEM_DW * rate_mult(HALF_RATE),
   localparam int unsigned PW       = ptr_width(DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                usr_rd_req,
   input  logic                usr_wr_req,
   input  logic [ADDR_W-1:0]   usr_addr,
   input  logic [SIZE_W-1:0]   usr_size,
   input  logic                usr_autopch,
   output logic                usr_ready,
   output logic                usr_proto_err,
   input  logic [LOCAL_DW-1:0] usr_wdata,
   output logic                usr_wdata_req,
   output logic                usr_init_done,
   output logic [LOCAL_DW-1:0] usr_rdata,
   output logic                usr_rdata_valid,
   output logic                usr_refresh_ack,
   input  logic                seq_user_mode_rdy,
   input  logic                iss_refresh_done,
   output logic                cmd_valid,
   input  logic                cmd_ready,
   output logic                cmd_write,
   output logic [ADDR_W-1:0]   cmd_addr,
   output logic [SIZE_W-1:0]   cmd_size,
   output logic                cmd_autopch,
   output logic [LOCAL_DW-1:0] cmd_wdata,
   input  logic [LOCAL_DW-1:0] phy_rdata,
   input  logic                phy_rdata_valid
);

   if (DEPTH < 2 || DEPTH > 64) begin : g_bad_depth
      $error("memreq_frontend: DEPTH must be in 2..64");
   end
   if (ADDR_W < 1 || SIZE_W < 1 || MEM_DW < 1) begin : g_bad_width
      $error("memreq_frontend: widths must be non-zero");
   end

   logic          full, accept, wr_accept, both;
   logic [PW-1:0] tail_slot, fill_slot;
   logic          fill_en;
   op_e           push_op, head_op;

   assign both      = usr_rd_req && usr_wr_req;
   assign usr_ready = !full;
   assign accept    = usr_ready && (usr_rd_req ^ usr_wr_req);
   assign push_op   = usr_wr_req ? OP_WRITE : OP_READ;
   assign wr_accept = accept && usr_wr_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) usr_proto_err <= 1'b0;
      else        usr_proto_err <= both;
   end

   memreq_queue #(
      .DEPTH (DEPTH),
      .ADDR_W(ADDR_W),
      .SIZE_W(SIZE_W),
      .DATA_W(LOCAL_DW)
   ) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (accept),
      .push_op   (push_op),
      .push_addr (usr_addr),
      .push_size (usr_size),
      .push_apch (usr_autopch),
      .tail_slot (tail_slot),
      .fill_en   (fill_en),
      .fill_slot (fill_slot),
      .fill_data (usr_wdata),
      .release_en(usr_init_done),
      .head_valid(cmd_valid),
      .head_take (cmd_ready),
      .head_op   (head_op),
      .head_addr (cmd_addr),
      .head_size (cmd_size),
      .head_apch (cmd_autopch),
      .head_data (cmd_wdata),
      .full      (full)
   );

   assign cmd_write = (head_op == OP_WRITE);

   memreq_wdpipe #(.PW(PW)) u_wdpipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_accept(wr_accept),
      .wr_slot  (tail_slot),
      .wdata_req(usr_wdata_req),
      .fill_en  (fill_en),
      .fill_slot(fill_slot)
   );

   memreq_status #(.LDW(LOCAL_DW)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .seq_rdy   (seq_user_mode_rdy),
      .ref_done  (iss_refresh_done),
      .phy_rdata (phy_rdata),
      .phy_rvalid(phy_rdata_valid),
      .init_done (usr_init_done),
      .ref_ack   (usr_refresh_ack),
      .rdata     (usr_rdata),
      .rvalid    (usr_rdata_valid)
   );

endmodule

// File: rtl/memreq_frontend_chk.sv
module memreq_frontend_chk #(
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned SIZE_W    = 3,
   parameter int unsigned DEPTH     = 4,
   parameter int unsigned MEM_DW    = 8,
   parameter bit          HALF_RATE = 1'b0,
   localparam int unsigned LOCAL_DW = MEM_DW * memreq_pkg::rate_mult(HALF_RATE)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                usr_rd_req,
   input logic                usr_wr_req,
   input logic                usr_ready,
   input logic                usr_proto_err,
   input logic                usr_wdata_req,
   input logic                usr_init_done,
   input logic                usr_rdata_valid,
   input logic                usr_refresh_ack,
   input logic                seq_user_mode_rdy,
   input logic                iss_refresh_done,
   input logic                cmd_valid,
   input logic                cmd_ready,
   input logic                cmd_write,
   input logic [ADDR_W-1:0]   cmd_addr,
   input logic [SIZE_W-1:0]   cmd_size,
   input logic                cmd_autopch,
   input logic [LOCAL_DW-1:0] cmd_wdata,
   input logic                phy_rdata_valid
);

   int unsigned occ;
   logic acc, pop;

   assign acc = usr_ready && (usr_rd_req ^ usr_wr_req);
   assign pop = cmd_valid && cmd_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ <= 0;
      else        occ <= occ + (acc ? 1 : 0) - (pop ? 1 : 0);
   end

   AST_FULL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == DEPTH) |-> !usr_ready); // R2
   AST_SPACE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (occ < DEPTH) |-> usr_ready); // R2
   AST_NO_ISSUE_BEFORE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      !usr_init_done |-> !cmd_valid); // R4
   AST_INIT_TRACKS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (usr_init_done == $past(seq_user_mode_rdy))); // R5
   AST_REFRESH_ACK_ON: assert property (@(posedge clk) disable iff (!rst_n)
      iss_refresh_done |=> usr_refresh_ack); // R6
   AST_REFRESH_ACK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !iss_refresh_done |=> !usr_refresh_ack); // R6
   AST_WDATA_REQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (usr_ready && usr_wr_req && !usr_rd_req) |=> usr_wdata_req); // R7
   AST_WDATA_REQ_ONLY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(usr_ready && usr_wr_req && !usr_rd_req) |=> !usr_wdata_req); // R7
   AST_BOTH_FLAGS_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
      (usr_rd_req && usr_wr_req) |=> usr_proto_err); // R8
   AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready && seq_user_mode_rdy) |=>
      (cmd_valid && $stable(cmd_addr) && $stable(cmd_size) && $stable(cmd_write)
       && $stable(cmd_autopch) && $stable(cmd_wdata))); // R9
   AST_RDATA_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (usr_rdata_valid == $past(phy_rdata_valid))); // R10

endmodule

bind memreq_frontend memreq_frontend_chk #(
   .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DEPTH(DEPTH), .MEM_DW(MEM_DW), .HALF_RATE(HALF_RATE)
) u_chk (.*);

// File: tb/memreq_frontend_test.sv
`timescale 1ns/1ps
module memreq_frontend_test;

   localparam int AW = 24, SW = 3, D = 4, LDW = 16, NCYC = 2400;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rd = 0, wr = 0, apch = 0, seq_rdy = 0, ref_in = 0, cready = 0, prv = 0;
   logic [AW-1:0]  addr = '0;
   logic [SW-1:0]  size = '0;
   logic [LDW-1:0] wdata = '0, prd = '0;
   logic ready, perr, wreq, idone, rvalid, rack, cvalid, cwrite, capch;
   logic [LDW-1:0] rdata, cwdata;
   logic [AW-1:0]  caddr;
   logic [SW-1:0]  csize;

   always #5 clk = ~clk;

   memreq_frontend uut (
      .clk(clk), .rst_n(rst_n), .usr_rd_req(rd), .usr_wr_req(wr), .usr_addr(addr),
      .usr_size(size), .usr_autopch(apch), .usr_ready(ready), .usr_proto_err(perr),
      .usr_wdata(wdata), .usr_wdata_req(wreq), .usr_init_done(idone), .usr_rdata(rdata),
      .usr_rdata_valid(rvalid), .usr_refresh_ack(rack), .seq_user_mode_rdy(seq_rdy),
      .iss_refresh_done(ref_in), .cmd_valid(cvalid), .cmd_ready(cready), .cmd_write(cwrite),
      .cmd_addr(caddr), .cmd_size(csize), .cmd_autopch(capch), .cmd_wdata(cwdata),
      .phy_rdata(prd), .phy_rdata_valid(prv));

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   // reference model state
   bit             m_wr [D];
   logic [AW-1:0]  m_addr [D];
   logic [SW-1:0]  m_size [D];
   bit             m_apch [D];
   logic [LDW-1:0] m_data [D];
   bit             m_dok [D];
   int m_head = 0, m_tail = 0, m_cnt = 0;
   bit m_init = 0, m_ref = 0, m_err = 0, m_wreq = 0, m_cap = 0, m_rv = 0;
   int m_wslot = 0, m_cslot = 0;
   logic [LDW-1:0] m_rd = '0;
   bit p_stall = 0;
   logic [AW-1:0] p_addr;
   logic [LDW-1:0] p_wdata;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit exp_ready();
      return m_cnt < D;
   endfunction

   function automatic bit exp_cvalid();
      return m_init && (m_cnt > 0) && m_dok[m_head];
   endfunction

   task automatic compare();
      chk("R2 ready", ready, exp_ready());
      chk("R4 cmd_valid", cvalid, exp_cvalid());
      chk("R5 init_done", idone, m_init);
      chk("R6 refresh_ack", rack, m_ref);
      chk("R7 wdata_req", wreq, m_wreq);
      chk("R8 proto_err", perr, m_err);
      chk("R10 rdata_valid", rvalid, m_rv);
      chk("R10 rdata", rdata, m_rd);
      if (exp_cvalid()) begin
         chk("R3 cmd_write", cwrite, m_wr[m_head]);
         chk("R3 cmd_addr", caddr, m_addr[m_head]);
         chk("R3 cmd_size", csize, m_size[m_head]);
         chk("R3 cmd_autopch", capch, m_apch[m_head]);
         if (m_wr[m_head]) chk("R7 cmd_wdata", cwdata, m_data[m_head]);
      end
      if (p_stall) begin
         chk("R9 held valid", cvalid, 1'b1);
         chk("R9 held addr", caddr, p_addr);
         chk("R9 held wdata", cwdata, p_wdata);
      end
   endtask

   task automatic step_model();
      bit cv, acc, pop;
      cv  = exp_cvalid();
      acc = exp_ready() && (rd ^ wr);
      pop = cv && cready;
      p_stall = cv && !cready && seq_rdy;
      p_addr  = caddr;
      p_wdata = cwdata;
      if (m_cap) begin
         m_data[m_cslot] = wdata;
         m_dok[m_cslot]  = 1;
      end
      m_cap   = m_wreq;
      m_cslot = m_wslot;
      m_wreq  = acc && wr;
      m_wslot = m_tail;
      if (pop) m_head = (m_head + 1) % D;
      if (acc) begin
         m_wr[m_tail]   = wr;
         m_addr[m_tail] = addr;
         m_size[m_tail] = size;
         m_apch[m_tail] = apch;
         m_dok[m_tail]  = !wr;
         m_tail = (m_tail + 1) % D;
      end
      m_cnt  = m_cnt + (acc ? 1 : 0) - (pop ? 1 : 0);
      m_init = seq_rdy;
      m_ref  = ref_in;
      m_err  = rd && wr;
      m_rv   = prv;
      if (prv) m_rd = prd;
   endtask

   task automatic drive(input int c);
      int r;
      r = $urandom % 10;
      rd = (r < 4) || (r == 8);
      wr = (r >= 4 && r < 8) || (r == 8);
      if (c == 5 || c == 300) begin rd = 1; wr = 1; end       // R8 directed
      addr  = AW'($urandom);
      size  = SW'($urandom);
      apch  = $urandom % 2;
      wdata = LDW'($urandom);
      seq_rdy = (c >= 40) && !(c >= 800 && c < 830);           // R4 before init and dropout
      cready  = (c >= 200 && c < 260) ? 1'b0 : (c >= 810 && c < 820) ? 1'b0 : (($urandom % 10) < 6);
      ref_in  = (c == 100 || c == 101) ? 1'b1 : (($urandom % 8) == 0); // R6
      prv     = $urandom % 2;
      prd     = LDW'($urandom);
   endtask

   initial begin
      void'($urandom(32'd20250611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11 reset state
      chk("R11 ready", ready, 1'b1);
      chk("R11 init_done", idone, 1'b0);
      chk("R11 cmd_valid", cvalid, 1'b0);
      chk("R11 wdata_req", wreq, 1'b0);
      chk("R11 proto_err", perr, 1'b0);
      chk("R11 refresh_ack", rack, 1'b0);
      chk("R11 rdata_valid", rvalid, 1'b0);
      rst_n = 1'b1;
      for (int c = 0; c < NCYC; c++) begin
         compare();                 // R1 covered via model acceptance
         drive(c);
         step_model();
         @(negedge clk);
      end
      chk("R1 queue drains count", m_cnt <= D, 1'b1);
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #((NCYC + 200) * 10);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule